// File: doc/BRIEF.md
# Clock Control Register Bank with Frequency Query

This block holds the clock-configuration registers of a small SoC in a bank of 32-bit words on a simple synchronous bus. Software reads and writes whole, aligned words. Any other access is refused with an error flag one cycle later.

Next to the bank sits a frequency calculator. A requester drives a clock selector and pulses a request strobe. The block then runs a multi-cycle sequential datapath over a snapshot of the PLL and clock-control words. It reports the resulting frequency in hertz together with a one-cycle completion pulse.

The computation chain has four stages, and each division truncates:
- PLL synthesis from a 24 MHz reference, or the reference itself in bypass.
- An optional three-quarter scaling.
- A CPU divider, followed by an AHB divider.
- A fixed halving for the peripheral clock.

Top module: `clk_ctrl_bank`

## Requirements
- R1: After reset every register reads zero except these, given by byte offset:
  - 0x00 = 0x800B2C01 and 0x04 = 0x84042800.
  - 0x08 = 0xD0030000.
  - 0x0C = 0x028A0100, 0x10 = 0x04008100 and 0x14 = 0x00000438.
  - 0x18, 0x1C, 0x20 and 0x24 = 0x01010101.
  - 0x58 = 0x00A00000, 0x5C = 0x0000A030 and 0x60 = 0x0000A030.
  - 0x64 = 0x43000000.

  With these values the peripheral clock query returns 33250000.
- R2: An access is valid when all three hold: the byte address is below 0x70, address bits 1:0 are zero, and all four byte enables are set. A valid write stores the word at index address>>2. A valid read returns that word on busRdata in the cycle after the request, with busErr low.
- R3: A read that is not valid returns 0 on busRdata with busErr high in the cycle after the request.
- R4: A write that is not valid changes no register and raises busErr in the cycle after the request.
- R5: The selector freqSel uses this encoding:
  - 0 is no clock and returns 0.
  - 1 and 2 both return the peripheral clock.
  - 3 returns 32768.
  - 4 returns the PLL, 5 the CPU clock and 6 the AHB clock.
  - 7 is unsupported and returns 0.
- R6: The PLL frequency is floor(48000000·(MFI·(MFD+1)+MFN) / ((MFD+1)·(PD+1))). The fields come from the word at offset 0x00: MFN = bits 9:0, MFI = bits 13:10 (values below 5 are treated as 5), MFD = bits 25:16 and PD = bits 29:26.
- R7: When bit 22 of the word at offset 0x08 is set, the PLL frequency is 24000000 regardless of offset 0x00.
- R8: The CPU frequency is computed in two steps from the word at offset 0x08. First, if bit 14 is set, the PLL value is replaced by floor(PLL·3/4). The result is then divided, with truncation, by 1 + bits 31:30.
- R9: The AHB frequency is floor(CPU / (1 + bits 29:28 of offset 0x08)). The peripheral frequency is floor(AHB/2).
- R10: freqDone is high for exactly one cycle per accepted request, and freqHz is valid in that cycle and stays unchanged until the next accepted request. A request arriving while a computation runs is ignored.
- R11: Register writes made while a computation runs do not affect its result. They apply to the next request.
- R12: A result above 0xFFFFFFFF is reported as 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReq | input | 1 | Bus access request |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address |
| busBe | input | 4 | Byte enables |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, one cycle after request |
| busErr | output | 1 | Access error, one cycle after request |
| freqReq | input | 1 | Frequency query strobe |
| freqSel | input | 3 | Clock selector |
| freqDone | output | 1 | One-cycle result-valid pulse |
| freqHz | output | 32 | Frequency result in hertz |

## Verification
The hardest situation to reach from the ports is a bus write landing in the middle of a long serial division, together with a second query strobe during the same window. The stimulus starts a CPU-clock query and, a few cycles in, rewrites the clock-control word and pulses a new request. It then checks that the first result reflects the old settings and that a fresh query sees the new ones. Random PLL and clock-control words, with MFI values below the clamp, bypass and scaling combinations, cover the arithmetic chain. One directed word pushes the PLL result past 32 bits to reach saturation.

// File: rtl/ccb_pkg.sv
package ccb_pkg;
  localparam int REF_HZ  = 24000000;
  localparam int SLOW_HZ = 32768;

  // PLL word field positions
  localparam int MFN_LSB = 0;
  localparam int MFN_W   = 10;
  localparam int MFI_LSB = 10;
  localparam int MFI_W   = 4;
  localparam int MFD_LSB = 16;
  localparam int MFD_W   = 10;
  localparam int PD_LSB  = 26;
  localparam int PD_W    = 4;
  localparam int MFI_MIN = 5;

  // clock-control word field positions
  localparam int CPUDIV_LSB = 30;
  localparam int AHBDIV_LSB = 28;
  localparam int DIV_W      = 2;
  localparam int BYPASS_BIT = 22;
  localparam int SRC_BIT    = 14;

  typedef enum logic [2:0] {
    SEL_NONE   = 3'd0,
    SEL_IPG    = 3'd1,
    SEL_IPGHI  = 3'd2,
    SEL_SLOW   = 3'd3,
    SEL_PLL    = 3'd4,
    SEL_CPU    = 3'd5,
    SEL_AHB    = 3'd6,
    SEL_UNSUP  = 3'd7
  } clkSel_e;

  typedef enum logic [1:0] {
    DIV_BY_PLL = 2'd0,
    DIV_BY_CPU = 2'd1,
    DIV_BY_AHB = 2'd2
  } divSel_e;

  typedef struct packed {
    logic    snap;
    logic    divGo;
    divSel_e divSel;
    logic    scale;
    logic    halve;
    logic    setZero;
    logic    setSlow;
  } ctrlStb_t;
endpackage

// File: rtl/ccb_regfile.sv
module ccb_regfile #(
  parameter int NUM_REGS = 28,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        busBe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busErr,
  output logic [DATA_W-1:0] pllWord,
  output logic [DATA_W-1:0] clkWord
);
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NUM_REGS * 4);

  function automatic logic [DATA_W-1:0] resetVal(input int idx);
    case (idx)
      0:              return DATA_W'(32'h800B2C01);
      1:              return DATA_W'(32'h84042800);
      2:              return DATA_W'(32'hD0030000);
      3:              return DATA_W'(32'h028A0100);
      4:              return DATA_W'(32'h04008100);
      5:              return DATA_W'(32'h00000438);
      6, 7, 8, 9:     return DATA_W'(32'h01010101);
      22:             return DATA_W'(32'h00A00000);
      23, 24:         return DATA_W'(32'h0000A030);
      25:             return DATA_W'(32'h43000000);
      default:        return '0;
    endcase
  endfunction

  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic             accOk;
  logic [IDX_W-1:0] idx;

  assign accOk = (busAddr < LIMIT) && (busAddr[1:0] == 2'b00) && (busBe == 4'hF);
  assign idx   = busAddr[IDX_W+1:2];

  for (genvar g = 0; g < NUM_REGS; g++) begin : gRegs
    always_ff @(posedge clk) begin
      if (!rstN) begin
        regs[g] <= resetVal(g);
      end else if (busReq && busWe && accOk && (idx == IDX_W'(g))) begin
        regs[g] <= busWdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata <= '0;
      busErr   <= 1'b0;
    end else begin
      busErr   <= busReq && !accOk;
      busRdata <= (busReq && !busWe && accOk) ? regs[idx] : '0;
    end
  end

  assign pllWord = regs[0];
  assign clkWord = regs[2];

  a_r3_err_outside: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busWe && busAddr >= LIMIT) |=> (busErr && busRdata == '0));

  a_r4_bad_write_kept: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWe && (busAddr[1:0] != 2'b00 || busBe != 4'hF)) |=> $stable(regs));

  a_r2_good_read_ok: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busWe && busAddr < LIMIT && busAddr[1:0] == 2'b00 && busBe == 4'hF)
      |=> !busErr);
endmodule

// File: rtl/ccb_ctrl.sv
module ccb_ctrl
  import ccb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       freqReq,
  input  logic [2:0] freqSel,
  input  logic       divBusy,
  output ctrlStb_t   stb,
  output logic       freqDone
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_SNAP, ST_DIV_PLL, ST_WAIT_PLL, ST_SCALE, ST_DIV_CPU,
    ST_WAIT_CPU, ST_DIV_AHB, ST_WAIT_AHB, ST_HALVE, ST_DONE
  } state_e;

  state_e  st, stNext;
  clkSel_e selQ;

  always_comb begin
    stb    = '0;
    stNext = st;
    case (st)
      ST_IDLE: begin
        if (freqReq) begin
          case (clkSel_e'(freqSel))
            SEL_NONE, SEL_UNSUP: begin stb.setZero = 1'b1; stNext = ST_DONE; end
            SEL_SLOW:            begin stb.setSlow = 1'b1; stNext = ST_DONE; end
            default:             begin stb.snap    = 1'b1; stNext = ST_DIV_PLL; end
          endcase
        end
      end
      ST_DIV_PLL: begin
        stb.divGo  = 1'b1;
        stb.divSel = DIV_BY_PLL;
        stNext     = ST_WAIT_PLL;
      end
      ST_WAIT_PLL: if (!divBusy) stNext = (selQ == SEL_PLL) ? ST_DONE : ST_SCALE;
      ST_SCALE: begin
        stb.scale = 1'b1;
        stNext    = ST_DIV_CPU;
      end
      ST_DIV_CPU: begin
        stb.divGo  = 1'b1;
        stb.divSel = DIV_BY_CPU;
        stNext     = ST_WAIT_CPU;
      end
      ST_WAIT_CPU: if (!divBusy) stNext = (selQ == SEL_CPU) ? ST_DONE : ST_DIV_AHB;
      ST_DIV_AHB: begin
        stb.divGo  = 1'b1;
        stb.divSel = DIV_BY_AHB;
        stNext     = ST_WAIT_AHB;
      end
      ST_WAIT_AHB: if (!divBusy) stNext = (selQ == SEL_AHB) ? ST_DONE : ST_HALVE;
      ST_HALVE: begin
        stb.halve = 1'b1;
        stNext    = ST_DONE;
      end
      ST_DONE: stNext = ST_IDLE;
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st   <= ST_IDLE;
      selQ <= SEL_NONE;
    end else begin
      st <= stNext;
      if (st == ST_IDLE && freqReq) selQ <= clkSel_e'(freqSel);
    end
  end

  assign freqDone = (st == ST_DONE);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    freqDone |=> !freqDone);

  a_r10_sel_held: assert property (@(posedge clk) disable iff (!rstN)
    (st != ST_IDLE) |=> $stable(selQ));

  a_r10_div_started: assert property (@(posedge clk) disable iff (!rstN)
    stb.divGo |=> divBusy);
endmodule

// File: rtl/ccb_datapath.sv
module ccb_datapath
  import ccb_pkg::*;
#(
  parameter int ACC_W = 48,
  parameter int OUT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStb_t         stb,
  input  logic [31:0]      pllWord,
  input  logic [31:0]      clkWord,
  output logic             divBusy,
  output logic [OUT_W-1:0] freqHz
);
  localparam int CNT_W = $clog2(ACC_W + 1);

  logic [MFN_W-1:0] mfn;
  logic [MFI_W-1:0] mfi, mfiClamp;
  logic [MFD_W-1:0] mfd;
  logic [PD_W-1:0]  pd;
  logic [ACC_W-1:0] pllNum, pllDen;

  assign mfn      = pllWord[MFN_LSB +: MFN_W];
  assign mfi      = pllWord[MFI_LSB +: MFI_W];
  assign mfd      = pllWord[MFD_LSB +: MFD_W];
  assign pd       = pllWord[PD_LSB +: PD_W];
  assign mfiClamp = (mfi < MFI_W'(MFI_MIN)) ? MFI_W'(MFI_MIN) : mfi;
  assign pllNum   = ACC_W'(2 * REF_HZ) *
                    (ACC_W'(mfiClamp) * (ACC_W'(mfd) + ACC_W'(1)) + ACC_W'(mfn));
  assign pllDen   = (ACC_W'(mfd) + ACC_W'(1)) * (ACC_W'(pd) + ACC_W'(1));

  logic [ACC_W-1:0] acc, rem, divisor, denSnap, divNext, remSh;
  logic [ACC_W+1:0] scaled;
  logic [31:0]      clkSnap;
  logic [CNT_W-1:0] cnt;
  logic             remGe;

  assign remSh  = {rem[ACC_W-2:0], acc[ACC_W-1]};
  assign remGe  = (remSh >= divisor);
  assign scaled = ({2'b00, acc} * (ACC_W+2)'(3)) >> 2;

  always_comb begin
    case (stb.divSel)
      DIV_BY_PLL: divNext = denSnap;
      DIV_BY_CPU: divNext = ACC_W'(clkSnap[CPUDIV_LSB +: DIV_W]) + ACC_W'(1);
      default:    divNext = ACC_W'(clkSnap[AHBDIV_LSB +: DIV_W]) + ACC_W'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc     <= '0;
      rem     <= '0;
      divisor <= ACC_W'(1);
      denSnap <= ACC_W'(1);
      clkSnap <= '0;
      cnt     <= '0;
      divBusy <= 1'b0;
    end else begin
      if (stb.snap) begin
        acc     <= clkWord[BYPASS_BIT] ? ACC_W'(REF_HZ) : pllNum;
        denSnap <= clkWord[BYPASS_BIT] ? ACC_W'(1) : pllDen;
        clkSnap <= clkWord;
      end
      if (stb.setZero) acc <= '0;
      if (stb.setSlow) acc <= ACC_W'(SLOW_HZ);
      if (stb.scale && clkSnap[SRC_BIT]) acc <= scaled[ACC_W-1:0];
      if (stb.halve) acc <= acc >> 1;
      if (stb.divGo) begin
        divisor <= divNext;
        rem     <= '0;
        cnt     <= CNT_W'(ACC_W);
        divBusy <= 1'b1;
      end else if (divBusy) begin
        acc <= {acc[ACC_W-2:0], remGe};
        rem <= remGe ? (remSh - divisor) : remSh;
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) divBusy <= 1'b0;
      end
    end
  end

  assign freqHz = (|acc[ACC_W-1:OUT_W]) ? '1 : acc[OUT_W-1:0];

  a_r9_divisor_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    divBusy |-> (divisor != '0));

  a_r11_snapshot_held: assert property (@(posedge clk) disable iff (!rstN)
    divBusy |=> $stable(clkSnap));
endmodule

// File: rtl/clk_ctrl_bank.sv
module clk_ctrl_bank
  import ccb_pkg::*;
#(
  parameter int NUM_REGS = 28,
  parameter int ADDR_W   = 12,
  parameter int ACC_W    = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        busBe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              busErr,
  input  logic              freqReq,
  input  logic [2:0]        freqSel,
  output logic              freqDone,
  output logic [31:0]       freqHz
);
  logic [31:0] pllWord, clkWord;
  logic        divBusy;
  ctrlStb_t    stb;

  ccb_regfile #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(32)) u_regs (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWe(busWe), .busAddr(busAddr),
    .busBe(busBe), .busWdata(busWdata), .busRdata(busRdata), .busErr(busErr),
    .pllWord(pllWord), .clkWord(clkWord)
  );

  ccb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .freqReq(freqReq), .freqSel(freqSel),
    .divBusy(divBusy), .stb(stb), .freqDone(freqDone)
  );

  ccb_datapath #(.ACC_W(ACC_W), .OUT_W(32)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .pllWord(pllWord), .clkWord(clkWord),
    .divBusy(divBusy), .freqHz(freqHz)
  );
endmodule

// File: tb/clk_ctrl_bank_bench.sv
`timescale 1ns/1ps
module clk_ctrl_bank_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busReq = 1'b0, busWe = 1'b0;
  logic [11:0] busAddr = '0;
  logic [3:0]  busBe = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busErr;
  logic        freqReq = 1'b0;
  logic [2:0]  freqSel = '0;
  logic        freqDone;
  logic [31:0] freqHz;

  int tests = 0, fails = 0;
  int cycles = 0;
  logic [31:0] shadow [28];

  always #2 clk = ~clk;

  clk_ctrl_bank u_clk_ctrl_bank (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWe(busWe), .busAddr(busAddr),
    .busBe(busBe), .busWdata(busWdata), .busRdata(busRdata), .busErr(busErr),
    .freqReq(freqReq), .freqSel(freqSel), .freqDone(freqDone), .freqHz(freqHz)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  function automatic logic [31:0] rstVal(input int i);
    if (i == 0) return 32'h800B2C01;
    if (i == 1) return 32'h84042800;
    if (i == 2) return 32'hD0030000;
    if (i == 3) return 32'h028A0100;
    if (i == 4) return 32'h04008100;
    if (i == 5) return 32'h00000438;
    if (i >= 6 && i <= 9) return 32'h01010101;
    if (i == 22) return 32'h00A00000;
    if (i == 23 || i == 24) return 32'h0000A030;
    if (i == 25) return 32'h43000000;
    return 32'h0;
  endfunction

  function automatic longint unsigned model(input logic [31:0] p, input logic [31:0] c,
                                            input int sel);
    longint unsigned mfn, mfi, mfd, pd, pll, cpu, ahb, ipg, r;
    mfn = longint'(p[9:0]);
    mfi = longint'(p[13:10]);
    if (mfi < 5) mfi = 5;
    mfd = longint'(p[25:16]);
    pd  = longint'(p[29:26]);
    if (c[22]) pll = 24000000;
    else pll = (64'd48000000 * (mfi * (mfd + 1) + mfn)) / ((mfd + 1) * (pd + 1));
    cpu = c[14] ? (pll * 3) / 4 : pll;
    cpu = cpu / (1 + longint'(c[31:30]));
    ahb = cpu / (1 + longint'(c[29:28]));
    ipg = ahb / 2;
    case (sel)
      1, 2: r = ipg;
      3: r = 32768;
      4: r = pll;
      5: r = cpu;
      6: r = ahb;
      default: r = 0;
    endcase
    if (r > 64'hFFFFFFFF) r = 64'hFFFFFFFF;
    return r;
  endfunction

  task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busAccess(input logic we, input logic [11:0] a, input logic [3:0] be,
                           input logic [31:0] d, output logic [31:0] rd, output logic err);
    @(negedge clk);
    busReq = 1'b1; busWe = we; busAddr = a; busBe = be; busWdata = d;
    @(negedge clk);
    busReq = 1'b0; busWe = 1'b0;
    rd = busRdata; err = busErr;
  endtask

  task automatic pulseReq(input int sel);
    @(negedge clk);
    freqReq = 1'b1; freqSel = 3'(sel);
    @(negedge clk);
    freqReq = 1'b0;
  endtask

  task automatic waitDone(input string req, output logic [31:0] res);
    int n = 0;
    while (!freqDone && n < 1000) begin
      @(negedge clk);
      n++;
    end
    check({req, " done seen"}, longint'(freqDone), 1);
    res = freqHz;
  endtask

  task automatic query(input string req, input int sel);
    logic [31:0] res;
    pulseReq(sel);
    waitDone(req, res);
    check(req, res, model(shadow[0], shadow[2], sel));
  endtask

  initial begin
    logic [31:0] rd, res, oldClk;
    logic err;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 28; i++) shadow[i] = rstVal(i);
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1: reset contents and reset-derived peripheral clock
    for (int i = 0; i < 28; i++) begin
      busAccess(1'b0, 12'(i * 4), 4'hF, '0, rd, err);
      check("R1 reset value", rd, rstVal(i));
    end
    check("R1 done idle at reset", longint'(freqDone), 0);
    query("R1 ipg from reset", 1);
    check("R1 ipg value", freqHz, 33250000);

    // R2: valid write/read
    busAccess(1'b1, 12'h028, 4'hF, 32'hA5A5_1234, rd, err);
    check("R2 write no error", longint'(err), 0);
    shadow[10] = 32'hA5A5_1234;
    busAccess(1'b0, 12'h028, 4'hF, '0, rd, err);
    check("R2 readback", rd, 32'hA5A5_1234);
    check("R2 read no error", longint'(err), 0);

    // R3: invalid reads
    busAccess(1'b0, 12'h070, 4'hF, '0, rd, err);
    check("R3 outside read data", rd, 0);
    check("R3 outside read err", longint'(err), 1);
    busAccess(1'b0, 12'h00A, 4'hF, '0, rd, err);
    check("R3 misaligned read err", longint'(err), 1);
    check("R3 misaligned read data", rd, 0);
    busAccess(1'b0, 12'h008, 4'h3, '0, rd, err);
    check("R3 narrow read err", longint'(err), 1);

    // R4: invalid writes ignored
    busAccess(1'b1, 12'h009, 4'hF, 32'hFFFF_FFFF, rd, err);
    check("R4 misaligned write err", longint'(err), 1);
    busAccess(1'b1, 12'h008, 4'h3, 32'hFFFF_FFFF, rd, err);
    check("R4 narrow write err", longint'(err), 1);
    busAccess(1'b1, 12'h070, 4'hF, 32'hFFFF_FFFF, rd, err);
    check("R4 outside write err", longint'(err), 1);
    busAccess(1'b0, 12'h008, 4'hF, '0, rd, err);
    check("R4 word unchanged", rd, shadow[2]);

    // R5: selector encodings, R9: both peripheral selectors, reset words
    for (int s = 0; s < 8; s++) query("R5 selector", s);

    // R6 clamp and R7 bypass directed
    shadow[0] = 32'h0003_0C05;  // MFI=3 (clamped), MFD=3, MFN=5
    busAccess(1'b1, 12'h000, 4'hF, shadow[0], rd, err);
    query("R6 pll clamp", 4);
    shadow[2] = 32'h0040_0000;
    busAccess(1'b1, 12'h008, 4'hF, shadow[2], rd, err);
    query("R7 bypass pll", 4);
    check("R7 bypass value", freqHz, 24000000);
    shadow[2] = 32'h5040_4000;
    busAccess(1'b1, 12'h008, 4'hF, shadow[2], rd, err);
    query("R8 bypass scaled cpu", 5);
    query("R9 bypass ipg", 2);

    // R12: saturation
    shadow[0] = 32'h0000_3FFF; shadow[2] = 32'h0;
    busAccess(1'b1, 12'h000, 4'hF, shadow[0], rd, err);
    busAccess(1'b1, 12'h008, 4'hF, shadow[2], rd, err);
    query("R12 saturated pll", 4);
    check("R12 value", freqHz, 32'hFFFF_FFFF);

    // R10 and R11: write and request during computation
    shadow[0] = 32'h800B2C01; shadow[2] = 32'hD0030000;
    busAccess(1'b1, 12'h000, 4'hF, shadow[0], rd, err);
    busAccess(1'b1, 12'h008, 4'hF, shadow[2], rd, err);
    oldClk = shadow[2];
    pulseReq(5);
    repeat (5) @(negedge clk);
    shadow[2] = 32'h0000_4000;
    busAccess(1'b1, 12'h008, 4'hF, shadow[2], rd, err);
    pulseReq(3);
    waitDone("R11 in-flight", res);
    check("R11 old settings used", res, model(shadow[0], oldClk, 5));
    @(negedge clk);
    check("R10 done one cycle", longint'(freqDone), 0);
    check("R10 result held", freqHz, res);
    repeat (10) @(negedge clk);
    check("R10 ignored request", freqHz, res);
    query("R11 next request sees write", 5);

    // Constrained random mix
    for (int it = 0; it < 40; it++) begin
      int idx;
      idx = int'($urandom_range(27, 0));
      shadow[idx] = $urandom();
      busAccess(1'b1, 12'(idx * 4), 4'hF, shadow[idx], rd, err);
      busAccess(1'b0, 12'(idx * 4), 4'hF, '0, rd, err);
      check("R2 random readback", rd, shadow[idx]);
      shadow[0] = $urandom() & 32'h3FFF_3FFF;
      if ($urandom_range(1, 0) == 1) shadow[0][25:16] = 10'($urandom_range(15, 0));
      shadow[2] = $urandom() & 32'hF040_4000;
      busAccess(1'b1, 12'h000, 4'hF, shadow[0], rd, err);
      busAccess(1'b1, 12'h008, 4'hF, shadow[2], rd, err);
      query("R6 R8 R9 random chain", int'($urandom_range(7, 0)));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule